// File: doc/BRIEF.md
# Processor Debug Halt Controller

This block decides when a processor core stops executing and enters the debug halted state, and when it may run again. It watches four halt sources and takes them in a fixed order of priority. A double fault or a permitted HALT instruction stops the core at the next clock edge. A hardware breakpoint trigger or the external breakpoint pin is only recorded as pending, and it stops the core at the next per-instruction sample strobe. A HALT instruction issued in user mode while user halts are disabled raises a privilege-violation request and does not halt. A GO command from the serial debug port releases a halted core.

After reset is released, the controller keeps the core out of reset exception processing for a fixed number of cycles. If the breakpoint pin is seen during the first part of that interval, the core halts before it runs anything. That halt is the only time the emulation-mode bit can be written. The controller drives a processor status code and a cause code that records which source produced the last halt.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the outputs after that edge are halt_o=0, priv_viol_o=0, pst_o=0x0, emu_o=0, cause_o=0 and boot_hold_o=1.
- R2: boot_hold_o stays 1 after each of the first 15 edges with rst_n high, and is 0 after the 16th, unless a reset-time halt is active.
- R3: If bkpt_i is high at any of the first 8 edges with rst_n high, halt_o becomes 1 and cause_o becomes 4 after that edge. A bkpt_i seen at the 9th to 16th edge has no effect, and is not kept pending.
- R4: Once boot hold is over and the core is running, fof_i high at an edge sets halt_o after that edge whether or not sample_i is high. cause_o becomes 1.
- R5: hwbp_i and bkpt_i pulses are kept pending across cycles. The core halts only at an edge where sample_i is high, with cause_o 2 for a hardware breakpoint and 4 for the pin.
- R6: halt_insn_i halts the core after that edge, with cause_o 3, when user_mode_i is 0 or uhe_i is 1.
- R7: halt_insn_i with user_mode_i=1 and uhe_i=0 does not halt. It gives a one-cycle priv_viol_o pulse after that edge, unless another source halts the core at the same edge.
- R8: When several sources fire at one edge, cause_o records only the highest: fault (1), then a sampled hardware breakpoint (2), then a HALT instruction (3), then a sampled pin breakpoint (4). cause_o keeps its value until the next halt.
- R9: go_i high at an edge while halted clears halt_o after that edge. go_i while running has no effect.
- R10: All pending halts are cleared when the halted state is entered, so the first sample after a GO does not halt unless a new source has fired.
- R11: pst_o reads 0xF while halt_o is 1 and 0x0 otherwise.
- R12: emu_wr_i loads emu_wdata_i into emu_o only while the reset-time halt is active. At any other time the write is ignored. emu_o keeps its value until reset.
- R13: While halted, every halt source is ignored. Nothing becomes pending, cause_o does not change and priv_viol_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fof_i | input | 1 | Fault-on-fault indication |
| hwbp_i | input | 1 | Hardware breakpoint trigger pulse |
| halt_insn_i | input | 1 | HALT instruction is executing this cycle |
| user_mode_i | input | 1 | Core is in user mode (0 = supervisor) |
| uhe_i | input | 1 | User-halt-enable control bit |
| bkpt_i | input | 1 | External breakpoint pin |
| sample_i | input | 1 | Per-instruction halt/interrupt sample strobe |
| go_i | input | 1 | GO command from the serial debug port |
| emu_wr_i | input | 1 | Write strobe for the emulation-mode bit |
| emu_wdata_i | input | 1 | Value to write to the emulation-mode bit |
| halt_o | output | 1 | Halt request to the core |
| priv_viol_o | output | 1 | Privilege-violation exception request pulse |
| pst_o | output | 4 | Processor status code |
| emu_o | output | 1 | Emulation-mode bit |
| cause_o | output | 3 | Cause of the most recent halt |
| boot_hold_o | output | 1 | Holds off reset exception processing |

## Verification
The main test drives all 128 combinations of fault, hardware breakpoint, HALT instruction, privilege mode, user-halt enable, pin breakpoint and sample strobe into a running core at one edge. This separates the immediate sources from the pending ones, and it separates each pair of sources on priority. After each combination a lone sample strobe shows whether a source that did not halt was kept pending. A GO and a further sample then show that the pending state is cleared and that a GO while running does nothing. While the core is halted, every source is driven at once to show that none is taken. The reset tests place the breakpoint at each edge from the first to the tenth after reset release, which finds the exact edge where the window closes and checks that the emulation bit can be written only inside it.

// File: rtl/dbg_halt_pkg.sv
// Package: shared types for the debug halt controller.
// Assumes: cause codes are visible to debug logic and must stay stable.
package dbg_halt_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_FAULT  = 3'd1,
        CAUSE_HWBRK  = 3'd2,
        CAUSE_HALTOP = 3'd3,
        CAUSE_EXTBRK = 3'd4
    } halt_cause_e;

    localparam logic [3:0] PST_RUN    = 4'h0;
    localparam logic [3:0] PST_HALTED = 4'hF;

    // Bit positions inside the pending vector
    localparam int PEND_HW = 0;
    localparam int PEND_BK = 1;
    localparam int PEND_N  = 2;

endpackage

// File: rtl/dbg_rst_window.sv
// Module: post-reset timing. Counts edges after reset release and saturates.
// busy_o is high during the hold-off interval; win_o is high during the
// shorter breakpoint window at its start.
// Assumes: WIN_CYC <= HOLD_CYC, synchronous active-low reset.
module dbg_rst_window #(
    parameter int HOLD_CYC = 16,
    parameter int WIN_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy_o,
    output logic win_o
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] WIN_V  = CNT_W'(WIN_CYC);

    logic [CNT_W-1:0] cnt_q;

    // Count edges since reset release, stopping at the hold limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != HOLD_V)
            cnt_q <= cnt_q + 1'b1;
    end

    // Decode both windows from the edge count
    always_comb begin
        busy_o = (cnt_q < HOLD_V);
        win_o  = (cnt_q < WIN_V);
    end

    AST_WIN_INSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        win_o |-> busy_o); // R3

    AST_HOLD_ENDS_FOR_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !busy_o); // R2

endmodule

// File: rtl/dbg_halt_pend.sv
// Module: sticky pending-halt flags, one per deferred source.
// Captures a request while capture is enabled and clears every flag when a
// halt is taken. eff_o shows the flag ORed with a request arriving now.
// Assumes: clr_i has priority over a capture in the same cycle.
module dbg_halt_pend #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en_i,
    input  logic         clr_i,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] eff_o
);
    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one pending request until a halt is taken
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= 1'b0;
            else if (clr_i)
                pend_q[i] <= 1'b0;
            else if (cap_en_i && req_i[i])
                pend_q[i] <= 1'b1;
        end
    end

    // Show stored flags together with requests arriving this cycle
    always_comb eff_o = pend_q | (req_i & {N{cap_en_i}});

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pend_q == '0)); // R10

    AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_i && !clr_i) |=> $stable(pend_q)); // R13

endmodule

// File: rtl/dbg_halt_arb.sv
// Module: fixed-priority selection among halt sources.
// Order: fault, sampled hardware breakpoint, HALT instruction, sampled pin.
// Assumes: en_i is low while halted or in boot hold; purely combinational.
module dbg_halt_arb
    import dbg_halt_pkg::*;
#(
    parameter int N = PEND_N
) (
    input  logic         en_i,
    input  logic         fault_i,
    input  logic         op_ok_i,
    input  logic         sample_i,
    input  logic [N-1:0] pend_i,
    output logic         take_o,
    output halt_cause_e  cause_o
);
    // Pick the winning source for this cycle
    always_comb begin
        take_o  = 1'b1;
        cause_o = CAUSE_NONE;
        if (!en_i)
            take_o = 1'b0;
        else if (fault_i)
            cause_o = CAUSE_FAULT;
        else if (sample_i && pend_i[PEND_HW])
            cause_o = CAUSE_HWBRK;
        else if (op_ok_i)
            cause_o = CAUSE_HALTOP;
        else if (sample_i && pend_i[PEND_BK])
            cause_o = CAUSE_EXTBRK;
        else
            take_o = 1'b0;
    end

    always_comb begin
        AST_TAKE_HAS_CAUSE: assert (!take_o || cause_o != CAUSE_NONE); // R8
    end

endmodule

// File: rtl/dbg_halt_ctrl.sv
// Module: debug halt controller top. Holds the halted state, the cause of
// the last halt, the privilege-violation pulse and the emulation-mode bit.
// Runs the reset-time breakpoint window.
// Assumes: inputs are synchronous to clk; GO arrives as a one-cycle strobe.
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int HOLD_CYC = 16,
    parameter int WIN_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fof_i,
    input  logic       hwbp_i,
    input  logic       halt_insn_i,
    input  logic       user_mode_i,
    input  logic       uhe_i,
    input  logic       bkpt_i,
    input  logic       sample_i,
    input  logic       go_i,
    input  logic       emu_wr_i,
    input  logic       emu_wdata_i,
    output logic       halt_o,
    output logic       priv_viol_o,
    output logic [3:0] pst_o,
    output logic       emu_o,
    output logic [2:0] cause_o,
    output logic       boot_hold_o
);
    logic        halt_q, rst_halt_q, priv_q, emu_q;
    halt_cause_e cause_q;
    logic        busy, win_open, run_en, op_ok, op_bad, take, win_take;
    logic [PEND_N-1:0] pend_req, pend_eff;
    halt_cause_e arb_cause;

    dbg_rst_window #(.HOLD_CYC(HOLD_CYC), .WIN_CYC(WIN_CYC)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .busy_o(busy),
        .win_o (win_open)
    );

    // Qualify the HALT instruction against privilege and the enable bit
    always_comb begin
        boot_hold_o = busy || rst_halt_q;
        run_en      = !halt_q && !boot_hold_o;
        op_ok       = halt_insn_i && (!user_mode_i || uhe_i);
        op_bad      = halt_insn_i && user_mode_i && !uhe_i;
        win_take    = win_open && bkpt_i && !halt_q;
        pend_req    = '0;
        pend_req[PEND_HW] = hwbp_i;
        pend_req[PEND_BK] = bkpt_i;
    end

    dbg_halt_pend #(.N(PEND_N)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en_i(run_en),
        .clr_i   (take),
        .req_i   (pend_req),
        .eff_o   (pend_eff)
    );

    dbg_halt_arb #(.N(PEND_N)) u_arb (
        .en_i    (run_en),
        .fault_i (fof_i),
        .op_ok_i (op_ok),
        .sample_i(sample_i),
        .pend_i  (pend_eff),
        .take_o  (take),
        .cause_o (arb_cause)
    );

    // Halted state, reset-halt flag and cause register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q     <= 1'b0;
            rst_halt_q <= 1'b0;
            cause_q    <= CAUSE_NONE;
        end else if (halt_q) begin
            if (go_i) begin
                halt_q     <= 1'b0;
                rst_halt_q <= 1'b0;
            end
        end else if (win_take) begin
            halt_q     <= 1'b1;
            rst_halt_q <= 1'b1;
            cause_q    <= CAUSE_EXTBRK;
        end else if (take) begin
            halt_q  <= 1'b1;
            cause_q <= arb_cause;
        end
    end

    // One-cycle privilege-violation request for a disallowed HALT
    always_ff @(posedge clk) begin
        if (!rst_n)
            priv_q <= 1'b0;
        else
            priv_q <= run_en && op_bad && !take;
    end

    // Emulation-mode bit, writable only during the reset-time halt
    always_ff @(posedge clk) begin
        if (!rst_n)
            emu_q <= 1'b0;
        else if (rst_halt_q && emu_wr_i)
            emu_q <= emu_wdata_i;
    end

    // Drive the outputs from state
    always_comb begin
        halt_o      = halt_q;
        priv_viol_o = priv_q;
        emu_o       = emu_q;
        cause_o     = cause_q;
        pst_o       = halt_q ? PST_HALTED : PST_RUN;
    end

    AST_GO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && go_i) |=> !halt_o); // R9

    AST_GO_NO_EFFECT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_o && go_i && !fof_i && !halt_insn_i && !sample_i && !bkpt_i) |=> !halt_o); // R9

    AST_PRIV_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol_o |-> !halt_o); // R7

    AST_FAULT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (fof_i && run_en) |=> (halt_o && cause_o == 3'd1)); // R4

    AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> (cause_o != 3'd0)); // R8

    AST_EMU_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_halt_q |=> $stable(emu_o)); // R12

    AST_CAUSE_HELD_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && $past(halt_o)) |-> $stable(cause_o)); // R13

endmodule

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fof_i = 0, hwbp_i = 0, halt_insn_i = 0, user_mode_i = 0, uhe_i = 0;
    logic       bkpt_i = 0, sample_i = 0, go_i = 0, emu_wr_i = 0, emu_wdata_i = 0;
    logic       halt_o, priv_viol_o, emu_o, boot_hold_o;
    logic [3:0] pst_o;
    logic [2:0] cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dbg_halt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fof_i(fof_i), .hwbp_i(hwbp_i),
        .halt_insn_i(halt_insn_i), .user_mode_i(user_mode_i), .uhe_i(uhe_i),
        .bkpt_i(bkpt_i), .sample_i(sample_i), .go_i(go_i), .emu_wr_i(emu_wr_i),
        .emu_wdata_i(emu_wdata_i), .halt_o(halt_o), .priv_viol_o(priv_viol_o),
        .pst_o(pst_o), .emu_o(emu_o), .cause_o(cause_o), .boot_hold_o(boot_hold_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        fof_i = 0; hwbp_i = 0; halt_insn_i = 0; user_mode_i = 0; uhe_i = 0;
        bkpt_i = 0; sample_i = 0; go_i = 0; emu_wr_i = 0; emu_wdata_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle();
        tick();
        tick();
        rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    function automatic logic [2:0] pick(input logic f, input logic h, input logic ok,
                                        input logic b, input logic s);
        if (f) return 3'd1;
        if (s && h) return 3'd2;
        if (ok) return 3'd3;
        if (s && b) return 3'd4;
        return 3'd0;
    endfunction

    initial begin
        logic [2:0] exp_cause;
        // R1 reset values
        do_reset();
        chk("R1 halt", halt_o, 0);
        chk("R1 priv", priv_viol_o, 0);
        chk("R1 pst", pst_o, 4'h0);
        chk("R1 emu", emu_o, 0);
        chk("R1 cause", cause_o, 0);
        chk("R1 hold", boot_hold_o, 1);
        // R2 boot hold length
        for (int k = 1; k <= 17; k++) begin
            tick();
            chk("R2 hold", boot_hold_o, (k < 16) ? 1 : 0);
        end

        // R3 / R12 breakpoint window sweep
        for (int k = 1; k <= 10; k++) begin
            do_reset();
            repeat (k - 1) tick();
            bkpt_i = 1;
            tick();
            bkpt_i = 0;
            if (k <= 8) begin
                chk("R3 window halt", halt_o, 1);
                chk("R11 pst halted", pst_o, 4'hF);
                chk("R3 cause", cause_o, 4);
                chk("R3 hold", boot_hold_o, 1);
                emu_wr_i = 1; emu_wdata_i = 1;
                tick();
                emu_wr_i = 0; emu_wdata_i = 0;
                chk("R12 emu set", emu_o, 1);
                go_i = 1;
                tick();
                go_i = 0;
                chk("R9 release", halt_o, 0);
                repeat (20) tick();
                chk("R2 hold end", boot_hold_o, 0);
                chk("R12 emu kept", emu_o, 1);
            end else begin
                chk("R3 late ignored", halt_o, 0);
                repeat (20) tick();
                sample_i = 1;
                tick();
                sample_i = 0;
                chk("R3 late not pending", halt_o, 0);
                emu_wr_i = 1; emu_wdata_i = 1;
                tick();
                emu_wr_i = 0; emu_wdata_i = 0;
                chk("R12 emu locked", emu_o, 0);
            end
        end

        // Fresh start for the main sweep
        do_reset();
        repeat (20) tick();
        exp_cause = 3'd0;
        for (int c = 0; c < 128; c++) begin
            logic f, h, op, um, ue, b, s, ok, bad, halted;
            logic [2:0] pc;
            f = c[0]; h = c[1]; op = c[2]; um = c[3]; ue = c[4]; b = c[5]; s = c[6];
            ok = op && (!um || ue);
            bad = op && um && !ue;
            pc = pick(f, h, ok, b, s);
            halted = (pc != 0);
            if (halted) exp_cause = pc;
            // step 1: the combination
            fof_i = f; hwbp_i = h; halt_insn_i = op; user_mode_i = um; uhe_i = ue;
            bkpt_i = b; sample_i = s;
            tick();
            idle();
            chk(f ? "R4 halt" : (pc == 3 ? "R6 halt" : "R5 halt"), halt_o, halted);
            chk("R8 cause", cause_o, exp_cause);
            chk("R7 priv", priv_viol_o, bad && !halted);
            chk("R11 pst", pst_o, halted ? 4'hF : 4'h0);
            // step 2
            if (halted) begin
                fof_i = 1; hwbp_i = 1; bkpt_i = 1; sample_i = 1; halt_insn_i = 1;
                user_mode_i = 1; emu_wr_i = 1; emu_wdata_i = 1;
                tick();
                idle();
                chk("R13 stay halted", halt_o, 1);
                chk("R13 cause kept", cause_o, exp_cause);
                chk("R13 no priv", priv_viol_o, 0);
                chk("R12 emu ignored", emu_o, 0);
                go_i = 1;
                tick();
                go_i = 0;
                chk("R9 go release", halt_o, 0);
                chk("R11 pst run", pst_o, 4'h0);
            end else begin
                sample_i = 1;
                tick();
                idle();
                if (h || b) exp_cause = h ? 3'd2 : 3'd4;
                chk("R5 pending sampled", halt_o, (h || b) ? 1 : 0);
                chk("R5 cause", cause_o, exp_cause);
                chk("R7 pulse one cycle", priv_viol_o, 0);
                go_i = 1;
                tick();
                go_i = 0;
                chk("R9 go", halt_o, 0);
            end
            // step 4: pending cleared
            sample_i = 1;
            tick();
            sample_i = 0;
            chk("R10 pending cleared", halt_o, 0);
        end

        // R5 persistence over idle cycles, both deferred sources
        for (int src = 0; src < 2; src++) begin
            if (src == 0) hwbp_i = 1; else bkpt_i = 1;
            tick();
            idle();
            repeat (3) begin
                tick();
                chk("R5 wait for sample", halt_o, 0);
            end
            sample_i = 1;
            tick();
            sample_i = 0;
            chk("R5 late sample halt", halt_o, 1);
            chk("R5 late cause", cause_o, (src == 0) ? 2 : 4);
            go_i = 1;
            tick();
            go_i = 0;
        end
        chk("R9 final released", halt_o, 0);
        finish_run();
    end

endmodule